// File: doc/BRIEF.md
# Overflow CAM Rearrangement Controller

This controller runs once after the repair tags for a memory have been loaded into a set-associative repair cache and a fully associative overflow CAM. It moves entries between the two arrays so that every live CAM entry ends up with a 1 in each upper-address position picked by a final mask. Later lookups can then test only those few upper address bits and skip the CAM search when the test fails. The arrays are not sorted. The controller keeps a mask shift register and clears bits out of it only as far as it has to.

The cache sets are handled one at a time, in ascending order. For each set, a counting pass finds two numbers. The first is how many live CAM entries belong to the set (their low address bits equal the set number). The second is how many live entries, in the CAM for that set plus in the set's ways, pass the current mask. If too few entries pass, the mask moves left by one place, a zero enters at the right, and the count is run again. Once enough entries pass, a swap pass trades each failing CAM entry of the set with a passing way of the same set. When the last set is finished, the controller raises `done` and shows the final mask.

Both arrays are reached through simple ports, one location at a time. Read data comes back one cycle after the read strobe. A swap writes one CAM entry and one way in the same cycle.

Top module: `ocam_rearrange`

## Requirements
- R1: On `start`, the mask is loaded with all ones and the set counter is reset to 0. The mask is never reloaded after that. Each later value of the mask has a 1 only where the value before it had a 1.
- R2: A location in either array is live only when its bad flag and its free flag are both 0. Locations that are not live are never counted, never chosen for a swap and never written. Their flags and tags come out of the run unchanged.
- R3: The counting pass for a set works as follows. Each live CAM entry whose low `SET_W` tag bits equal the set number adds one to the set count. Each such entry that also passes the mask test adds one to the pass count. Each live way of the set that passes the mask test adds one to the pass count. The mask test passes when (top `MASK_W` address bits AND mask) equals the mask. The counters are wide enough never to wrap.
- R4: If the pass count is less than the set count, the mask shifts left with a 0 entering bit 0 and the counting pass runs again. Otherwise the swap pass for that set starts.
- R5: In the swap pass, each live CAM entry of the current set that fails the mask test is paired with the lowest-numbered live way of the set that passes the test and has not already been used in this pass. The CAM location receives {way tag, set number}. The way receives bits `ADDR_W-1:SET_W` of the old CAM tag. Both writes happen in the same cycle.
- R6: Sets are handled from 0 upwards. After the set with all ones has been handled, `done` goes high and stays high until the next `start`. `finalMask` shows the mask.
- R7: At `done`, every live CAM entry passes the mask test against `finalMask`.
- R8: At `done`, the multiset of stored addresses is the same as at `start`. A live CAM entry stores its tag as its address. A live way stores {tag, set}.
- R9: At most one read strobe, CAM or cache, is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a rearrangement run (accepted when idle or done) |
| done | output | 1 | High from the end of a run until the next start |
| finalMask | output | MASK_W | Current mask; the final mask once done is high |
| camRdEn | output | 1 | CAM read strobe; data is returned on the next cycle |
| camWrEn | output | 1 | CAM tag write strobe |
| camAddr | output | CAM_AW | CAM location for reads and writes |
| camWrTag | output | ADDR_W | Tag written into the CAM |
| camRdTag | input | ADDR_W | Tag read from the CAM |
| camRdBad | input | 1 | Bad flag of the CAM location that was read |
| camRdFree | input | 1 | Free flag of the CAM location that was read |
| cacheRdEn | output | 1 | Cache read strobe; data is returned on the next cycle |
| cacheWrEn | output | 1 | Cache tag write strobe |
| cacheSet | output | SET_W | Cache set for reads and writes |
| cacheWay | output | WAY_AW | Cache way for reads and writes |
| cacheWrTag | output | ADDR_W-SET_W | Tag written into the cache way |
| cacheRdTag | input | ADDR_W-SET_W | Tag read from the cache way |
| cacheRdBad | input | 1 | Bad flag of the way that was read |
| cacheRdFree | input | 1 | Free flag of the way that was read |

## Verification
The assertions take three things for granted. Nothing else writes either tag array while a run is in progress. Read data is valid on the cycle after each strobe. `start` arrives only while the controller is idle or done. The stimulus meets all three: the array models in the bench are filled only before `start` is pulsed, they change only through the controller's write strobes, and they return registered read data. Under those conditions, the swap-pairing property and the counting properties hold, because every live entry the controller sees stays as it was read until the controller itself writes it.

// File: rtl/rearr_pkg.sv
`timescale 1ns/1ps
package rearr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CNT_CAM_RD,
    ST_CNT_CAM_EV,
    ST_CNT_WAY_RD,
    ST_CNT_WAY_EV,
    ST_DECIDE,
    ST_SWP_CAM_RD,
    ST_SWP_CAM_EV,
    ST_SWP_WAY_RD,
    ST_SWP_WAY_EV,
    ST_SET_END,
    ST_DONE
  } rearr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic initRun;
    logic restartScan;
    logic incCam;
    logic incCnt3;
    logic incCnt4;
    logic shiftMask;
    logic clrWay;
    logic incWay;
    logic loadReg1;
    logic clrUsed;
    logic markUsed;
    logic incSet;
    logic swapWr;
  } rearr_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic camValid;
    logic camSetHit;
    logic camPass;
    logic wayValid;
    logic wayPass;
    logic wayUsed;
    logic camLast;
    logic wayLast;
    logic setLast;
    logic countOk;
  } rearr_status_t;

endpackage

// File: rtl/rearr_dpath.sv
`timescale 1ns/1ps
module rearr_dpath
  import rearr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SET_W     = 2,
  parameter int MASK_W    = 3,
  parameter int CAM_DEPTH = 4,
  parameter int WAYS      = 2
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  rearr_strobe_t                               strb,
  input  logic [ADDR_W-1:0]                           camRdTag,
  input  logic                                        camRdBad,
  input  logic                                        camRdFree,
  input  logic [ADDR_W-SET_W-1:0]                     cacheRdTag,
  input  logic                                        cacheRdBad,
  input  logic                                        cacheRdFree,
  output rearr_status_t                               stat,
  output logic [(CAM_DEPTH > 1 ? $clog2(CAM_DEPTH) : 1)-1:0] camAddr,
  output logic [ADDR_W-1:0]                           camWrTag,
  output logic [SET_W-1:0]                            cacheSet,
  output logic [(WAYS > 1 ? $clog2(WAYS) : 1)-1:0]    cacheWay,
  output logic [ADDR_W-SET_W-1:0]                     cacheWrTag,
  output logic [MASK_W-1:0]                           finalMask
);

  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int CAM_AW = (CAM_DEPTH > 1) ? $clog2(CAM_DEPTH) : 1;
  localparam int WAY_AW = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CNT_W  = $clog2(CAM_DEPTH + WAYS + 1);

  logic [MASK_W-1:0] mask;
  logic [SET_W-1:0]  setCnt;
  logic [CNT_W-1:0]  cnt3;
  logic [CNT_W-1:0]  cnt4;
  logic [ADDR_W-1:0] reg1;
  logic [CAM_AW-1:0] camIdx;
  logic [WAY_AW-1:0] wayIdx;
  logic [WAYS-1:0]   usedWays;
  logic              reg1Pass;

  // mask register: all ones at start, only ever loses ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mask <= '1;
    end else if (strb.initRun) begin
      mask <= '1;
    end else if (strb.shiftMask) begin
      mask <= mask << 1;
    end
  end

  // set counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setCnt <= '0;
    end else if (strb.initRun) begin
      setCnt <= '0;
    end else if (strb.incSet) begin
      setCnt <= setCnt + SET_W'(1);
    end
  end

  // counters and CAM scan index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt3   <= '0;
      cnt4   <= '0;
      camIdx <= '0;
    end else if (strb.restartScan) begin
      cnt3   <= '0;
      cnt4   <= '0;
      camIdx <= '0;
    end else begin
      if (strb.incCnt3) cnt3 <= cnt3 + CNT_W'(1);
      if (strb.incCnt4) cnt4 <= cnt4 + CNT_W'(1);
      if (strb.incCam)  camIdx <= camIdx + CAM_AW'(1);
    end
  end

  // way scan index and holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wayIdx <= '0;
      reg1   <= '0;
    end else begin
      if (strb.clrWay)      wayIdx <= '0;
      else if (strb.incWay) wayIdx <= wayIdx + WAY_AW'(1);
      if (strb.loadReg1)    reg1 <= camRdTag;
    end
  end

  // one "already swapped in" bit per way
  for (genvar w = 0; w < WAYS; w++) begin : g_used
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        usedWays[w] <= 1'b0;
      end else if (strb.clrUsed) begin
        usedWays[w] <= 1'b0;
      end else if (strb.markUsed && (wayIdx == WAY_AW'(w))) begin
        usedWays[w] <= 1'b1;
      end
    end
  end

  // evaluation of returned read data
  always_comb begin
    stat           = '0;
    stat.camValid  = !camRdBad && !camRdFree;
    stat.camSetHit = (camRdTag[SET_W-1:0] == setCnt);
    stat.camPass   = ((camRdTag[ADDR_W-1 -: MASK_W] & mask) == mask);
    stat.wayValid  = !cacheRdBad && !cacheRdFree;
    stat.wayPass   = ((cacheRdTag[TAG_W-1 -: MASK_W] & mask) == mask);
    stat.wayUsed   = usedWays[wayIdx];
    stat.camLast   = (camIdx == CAM_AW'(CAM_DEPTH - 1));
    stat.wayLast   = (wayIdx == WAY_AW'(WAYS - 1));
    stat.setLast   = &setCnt;
    stat.countOk   = (cnt4 >= cnt3);
  end

  assign reg1Pass   = ((reg1[ADDR_W-1 -: MASK_W] & mask) == mask);
  assign camAddr    = camIdx;
  assign camWrTag   = {cacheRdTag, setCnt};
  assign cacheSet   = setCnt;
  assign cacheWay   = wayIdx;
  assign cacheWrTag = reg1[ADDR_W-1:SET_W];
  assign finalMask  = mask;

  AST_MASK_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    !strb.initRun |=> ((mask & ~$past(mask)) == '0));  // R1

  AST_SHIFT_ONLY_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftMask |-> (cnt4 < cnt3));  // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCnt4 || strb.incCnt3) |-> ((cnt4 != '1) && (cnt3 != '1)));  // R3

  AST_SWAP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    strb.swapWr |-> ((reg1[SET_W-1:0] == setCnt) && !reg1Pass));  // R5

endmodule

// File: rtl/rearr_ctrl.sv
`timescale 1ns/1ps
module rearr_ctrl
  import rearr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  rearr_status_t stat,
  output rearr_strobe_t strb,
  output logic          camRdEn,
  output logic          cacheRdEn,
  output logic          done
);

  rearr_state_e st;
  rearr_state_e nxt;
  logic         moveOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    strb      = '0;
    nxt       = st;
    camRdEn   = 1'b0;
    cacheRdEn = 1'b0;
    moveOn    = 1'b0;
    case (st)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strb.initRun     = 1'b1;
          strb.restartScan = 1'b1;
          nxt              = ST_CNT_CAM_RD;
        end
      end
      ST_CNT_CAM_RD: begin
        camRdEn = 1'b1;
        nxt     = ST_CNT_CAM_EV;
      end
      ST_CNT_CAM_EV: begin
        if (stat.camValid && stat.camSetHit) begin
          strb.incCnt3 = 1'b1;
          strb.incCnt4 = stat.camPass;
        end
        if (stat.camLast) begin
          strb.clrWay = 1'b1;
          nxt         = ST_CNT_WAY_RD;
        end else begin
          strb.incCam = 1'b1;
          nxt         = ST_CNT_CAM_RD;
        end
      end
      ST_CNT_WAY_RD: begin
        cacheRdEn = 1'b1;
        nxt       = ST_CNT_WAY_EV;
      end
      ST_CNT_WAY_EV: begin
        strb.incCnt4 = stat.wayValid && stat.wayPass;
        if (stat.wayLast) begin
          nxt = ST_DECIDE;
        end else begin
          strb.incWay = 1'b1;
          nxt         = ST_CNT_WAY_RD;
        end
      end
      ST_DECIDE: begin
        strb.restartScan = 1'b1;
        if (stat.countOk) begin
          strb.clrUsed = 1'b1;
          nxt          = ST_SWP_CAM_RD;
        end else begin
          strb.shiftMask = 1'b1;
          nxt            = ST_CNT_CAM_RD;
        end
      end
      ST_SWP_CAM_RD: begin
        camRdEn = 1'b1;
        nxt     = ST_SWP_CAM_EV;
      end
      ST_SWP_CAM_EV: begin
        if (stat.camValid && stat.camSetHit && !stat.camPass) begin
          strb.loadReg1 = 1'b1;
          strb.clrWay   = 1'b1;
          nxt           = ST_SWP_WAY_RD;
        end else begin
          moveOn = 1'b1;
        end
      end
      ST_SWP_WAY_RD: begin
        cacheRdEn = 1'b1;
        nxt       = ST_SWP_WAY_EV;
      end
      ST_SWP_WAY_EV: begin
        if (stat.wayValid && stat.wayPass && !stat.wayUsed) begin
          strb.swapWr   = 1'b1;
          strb.markUsed = 1'b1;
          moveOn        = 1'b1;
        end else if (stat.wayLast) begin
          moveOn = 1'b1;
        end else begin
          strb.incWay = 1'b1;
          nxt         = ST_SWP_WAY_RD;
        end
      end
      ST_SET_END: begin
        if (stat.setLast) begin
          nxt = ST_DONE;
        end else begin
          strb.incSet      = 1'b1;
          strb.restartScan = 1'b1;
          nxt              = ST_CNT_CAM_RD;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (moveOn) begin
      if (stat.camLast) begin
        nxt = ST_SET_END;
      end else begin
        strb.incCam = 1'b1;
        nxt         = ST_SWP_CAM_RD;
      end
    end
  end

  assign done = (st == ST_DONE);

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    !(camRdEn && cacheRdEn));  // R9

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);  // R6

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !strb.swapWr);  // R2

endmodule

// File: rtl/ocam_rearrange.sv
`timescale 1ns/1ps
module ocam_rearrange
  import rearr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SET_W     = 2,
  parameter int MASK_W    = 3,
  parameter int CAM_DEPTH = 4,
  parameter int WAYS      = 2,
  localparam int CAM_AW   = (CAM_DEPTH > 1) ? $clog2(CAM_DEPTH) : 1,
  localparam int WAY_AW   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W    = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  output logic [MASK_W-1:0] finalMask,
  output logic              camRdEn,
  output logic              camWrEn,
  output logic [CAM_AW-1:0] camAddr,
  output logic [ADDR_W-1:0] camWrTag,
  input  logic [ADDR_W-1:0] camRdTag,
  input  logic              camRdBad,
  input  logic              camRdFree,
  output logic              cacheRdEn,
  output logic              cacheWrEn,
  output logic [SET_W-1:0]  cacheSet,
  output logic [WAY_AW-1:0] cacheWay,
  output logic [TAG_W-1:0]  cacheWrTag,
  input  logic [TAG_W-1:0]  cacheRdTag,
  input  logic              cacheRdBad,
  input  logic              cacheRdFree
);

  rearr_strobe_t strb;
  rearr_status_t stat;

  rearr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stat      (stat),
    .strb      (strb),
    .camRdEn   (camRdEn),
    .cacheRdEn (cacheRdEn),
    .done      (done)
  );

  rearr_dpath #(
    .ADDR_W    (ADDR_W),
    .SET_W     (SET_W),
    .MASK_W    (MASK_W),
    .CAM_DEPTH (CAM_DEPTH),
    .WAYS      (WAYS)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .camRdTag    (camRdTag),
    .camRdBad    (camRdBad),
    .camRdFree   (camRdFree),
    .cacheRdTag  (cacheRdTag),
    .cacheRdBad  (cacheRdBad),
    .cacheRdFree (cacheRdFree),
    .stat        (stat),
    .camAddr     (camAddr),
    .camWrTag    (camWrTag),
    .cacheSet    (cacheSet),
    .cacheWay    (cacheWay),
    .cacheWrTag  (cacheWrTag),
    .finalMask   (finalMask)
  );

  assign camWrEn   = strb.swapWr;
  assign cacheWrEn = strb.swapWr;

endmodule

// File: tb/ocam_rearrange_tb.sv
`timescale 1ns/1ps
module ocam_rearrange_tb;

  // entry encodings: CAM {bad, free, tag[7:0]}, way {bad, free, tag[5:0]}
  typedef struct packed {
    logic [3:0][9:0] cam;
    logic [7:0][7:0] way;   // index = set*2 + way
    logic [2:0]      expMask;
    logic [3:0][9:0] expCam;
    logic [7:0][7:0] expWay;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    // empty CAM: nothing to do
    '{cam:{10'h100,10'h100,10'h100,10'h100},
      way:{8'h08,8'h07,8'h06,8'h05,8'h04,8'h03,8'h02,8'h01}, expMask:3'b111,
      expCam:{10'h100,10'h100,10'h100,10'h100},
      expWay:{8'h08,8'h07,8'h06,8'h05,8'h04,8'h03,8'h02,8'h01}},
    // CAM entry already passes
    '{cam:{10'h100,10'h100,10'h100,10'h0E1},
      way:{8'h08,8'h07,8'h06,8'h05,8'h04,8'h03,8'h02,8'h01}, expMask:3'b111,
      expCam:{10'h100,10'h100,10'h100,10'h0E1},
      expWay:{8'h08,8'h07,8'h06,8'h05,8'h04,8'h03,8'h02,8'h01}},
    // single swap at full mask
    '{cam:{10'h100,10'h100,10'h100,10'h022},
      way:{8'h40,8'h40,8'h05,8'h3F,8'h40,8'h40,8'h40,8'h40}, expMask:3'b111,
      expCam:{10'h100,10'h100,10'h100,10'h0FE},
      expWay:{8'h40,8'h40,8'h05,8'h08,8'h40,8'h40,8'h40,8'h40}},
    // mask relaxes twice, then swap
    '{cam:{10'h100,10'h100,10'h100,10'h022},
      way:{8'h40,8'h40,8'h11,8'h20,8'h40,8'h40,8'h40,8'h40}, expMask:3'b100,
      expCam:{10'h100,10'h100,10'h100,10'h082},
      expWay:{8'h40,8'h40,8'h11,8'h08,8'h40,8'h40,8'h40,8'h40}},
    // bad and free entries ignored, bad way skipped
    '{cam:{10'h100,10'h003,10'h103,10'h203},
      way:{8'h3E,8'hBF,8'h40,8'h40,8'h40,8'h40,8'h40,8'h40}, expMask:3'b111,
      expCam:{10'h100,10'h0FB,10'h103,10'h203},
      expWay:{8'h00,8'hBF,8'h40,8'h40,8'h40,8'h40,8'h40,8'h40}},
    // mask collapses to zero, no swap
    '{cam:{10'h100,10'h100,10'h004,10'h000},
      way:{8'h40,8'h40,8'h40,8'h40,8'h40,8'h40,8'h08,8'h10}, expMask:3'b000,
      expCam:{10'h100,10'h100,10'h004,10'h000},
      expWay:{8'h40,8'h40,8'h40,8'h40,8'h40,8'h40,8'h08,8'h10}},
    // two swaps in one set, second uses the next way
    '{cam:{10'h100,10'h100,10'h005,10'h001},
      way:{8'h40,8'h40,8'h40,8'h40,8'h3E,8'h3F,8'h40,8'h40}, expMask:3'b111,
      expCam:{10'h100,10'h100,10'h0F9,10'h0FD},
      expWay:{8'h40,8'h40,8'h40,8'h40,8'h01,8'h00,8'h40,8'h40}}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       done;
  logic [2:0] finalMask;
  logic       camRdEn, camWrEn, cacheRdEn, cacheWrEn;
  logic [1:0] camAddr;
  logic [7:0] camWrTag;
  logic [7:0] camRdTag;
  logic       camRdBad, camRdFree;
  logic [1:0] cacheSet;
  logic [0:0] cacheWay;
  logic [5:0] cacheWrTag, cacheRdTag;
  logic       cacheRdBad, cacheRdFree;

  logic [9:0] camMem [4];
  logic [7:0] wayMem [8];

  int checks = 0;
  int fails = 0;
  int bothRd = 0;

  always #2 clk = ~clk;

  ocam_rearrange u_dut (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .finalMask(finalMask),
    .camRdEn(camRdEn), .camWrEn(camWrEn), .camAddr(camAddr), .camWrTag(camWrTag),
    .camRdTag(camRdTag), .camRdBad(camRdBad), .camRdFree(camRdFree),
    .cacheRdEn(cacheRdEn), .cacheWrEn(cacheWrEn), .cacheSet(cacheSet),
    .cacheWay(cacheWay), .cacheWrTag(cacheWrTag), .cacheRdTag(cacheRdTag),
    .cacheRdBad(cacheRdBad), .cacheRdFree(cacheRdFree)
  );

  // array models: registered reads, tag-only writes
  always @(posedge clk) begin
    if (camWrEn) camMem[camAddr][7:0] <= camWrTag;
    if (camRdEn) begin
      camRdTag  <= camMem[camAddr][7:0];
      camRdBad  <= camMem[camAddr][9];
      camRdFree <= camMem[camAddr][8];
    end
    if (cacheWrEn) wayMem[{cacheSet, cacheWay}][5:0] <= cacheWrTag;
    if (cacheRdEn) begin
      cacheRdTag  <= wayMem[{cacheSet, cacheWay}][5:0];
      cacheRdBad  <= wayMem[{cacheSet, cacheWay}][7];
      cacheRdFree <= wayMem[{cacheSet, cacheWay}][6];
    end
    if (camRdEn && cacheRdEn) bothRd <= bothRd + 1;
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  task automatic run_vec(input int v);
    int  bal [256];
    int  n;
    bit  ok;
    for (int a = 0; a < 256; a++) bal[a] = 0;
    @(negedge clk);
    for (int e = 0; e < 4; e++) begin
      camMem[e] = VECS[v].cam[e];
      if (VECS[v].cam[e][9:8] == 2'b00) bal[VECS[v].cam[e][7:0]]++;
    end
    for (int w = 0; w < 8; w++) begin
      wayMem[w] = VECS[v].way[w];
      if (VECS[v].way[w][7:6] == 2'b00) bal[{VECS[v].way[w][5:0], w[2:1]}]++;
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: mask reloaded to all ones on start
    check(finalMask == 3'b111, $sformatf("R1 mask at start v%0d", v), 64'(finalMask), 64'h7);
    // R6: done drops once a run is under way
    check(done == 1'b0, $sformatf("R6 done low while busy v%0d", v), 64'(done), 64'h0);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, $sformatf("R6 run finishes v%0d", v), 64'(done), 64'h1);
    // R4: mask narrowed exactly as far as needed
    check(finalMask == VECS[v].expMask, $sformatf("R4 final mask v%0d", v),
          64'(finalMask), 64'(VECS[v].expMask));
    // R5 and R2: exact contents after swaps, untouched non-live entries
    for (int e = 0; e < 4; e++)
      check(camMem[e] == VECS[v].expCam[e], $sformatf("R5 R2 CAM entry %0d v%0d", e, v),
            64'(camMem[e]), 64'(VECS[v].expCam[e]));
    for (int w = 0; w < 8; w++)
      check(wayMem[w] == VECS[v].expWay[w], $sformatf("R5 R2 way %0d v%0d", w, v),
            64'(wayMem[w]), 64'(VECS[v].expWay[w]));
    // R7: every live CAM entry passes the final mask
    for (int e = 0; e < 4; e++) begin
      ok = (camMem[e][9:8] != 2'b00) || ((camMem[e][7:5] & finalMask) == finalMask);
      check(ok, $sformatf("R7 CAM entry %0d vs mask v%0d", e, v), 64'(camMem[e]), 64'(finalMask));
    end
    // R8: stored address multiset unchanged
    for (int e = 0; e < 4; e++)
      if (camMem[e][9:8] == 2'b00) bal[camMem[e][7:0]]--;
    for (int w = 0; w < 8; w++)
      if (wayMem[w][7:6] == 2'b00) bal[{wayMem[w][5:0], w[2:1]}]--;
    ok = 1'b1;
    for (int a = 0; a < 256; a++) if (bal[a] != 0) ok = 1'b0;
    check(ok, $sformatf("R8 address multiset v%0d", v), 64'(ok), 64'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(done == 1'b0, "R6 done low in reset", 64'(done), 64'h0);
    check(!camRdEn && !cacheRdEn, "R9 no reads in reset", 64'({camRdEn, cacheRdEn}), 64'h0);
    check(!camWrEn && !cacheWrEn, "R2 no writes in reset", 64'({camWrEn, cacheWrEn}), 64'h0);
    check(finalMask == 3'b111, "R1 mask all ones in reset", 64'(finalMask), 64'h7);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R6 done stays low without start", 64'(done), 64'h0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // vector 5 left the mask at zero; R1 reload on a restart from done
    run_vec(5);
    run_vec(0);

    repeat (5) @(negedge clk);
    check(done == 1'b1, "R6 done holds until next start", 64'(done), 64'h1);
    check(bothRd == 0, "R9 CAM and cache never read together", 64'(bothRd), 64'h0);
    summary();
  end

endmodule